// File: doc/BRIEF.md
# Byte-Stream Escape Decoder

This block splits one incoming byte stream into two outgoing streams. One of them carries ordinary payload and is called the data stream. The other, the control stream, carries bytes that were marked by a reserved escape byte (0xA5).

A payload byte with no escape in front of it goes to the data stream unchanged. An escape byte followed by a second escape stands for one literal 0xA5 on the data stream. An escape byte followed by any other value sends that value to the control stream, and the data stream gets nothing. Escapes pair up from left to right, so a run of escapes is used two at a time. Any odd one left at the end of a run escapes the byte that follows it.

All three ports use a valid/ready handshake. The path from input to output is combinational, with no added latency. The only state is one bit that records a pending escape.

Top module: `esc_unescaper`

## Requirements
- R1: With no escape pending, an input byte other than 0xA5 appears unchanged on the data output (`dat_valid`, `dat_byte`) in the same cycle, and the control output stays idle.
- R2: An escape byte followed by a second 0xA5 produces exactly one 0xA5 on the data output and nothing on the control output.
- R3: An escape byte followed by a value x other than 0xA5 produces x on the control output (`ctl_valid`, `ctl_byte`), and the data output stays idle. A byte on the control output is never 0xA5.
- R4: In any cycle, at most one of `dat_valid` and `ctl_valid` is high.
- R5: Escapes are consumed in pairs from left to right. For example, A5 A5 A5 07 gives 0xA5 on data and then 07 on control, and A5 A5 A5 A5 gives two 0xA5 on data. The pending bit is set when an unpaired escape is accepted and cleared when the next byte is accepted.
- R6: A byte routed to the data output is accepted (`src_ready` high) only while `dat_ready` is high. A byte routed to the control output is accepted only while `ctl_ready` is high. While no byte is accepted, the pending state does not change and the offered byte is held on the output.
- R7: An unpaired escape byte, with no escape pending, is always accepted, whatever the state of `dat_ready` and `ctl_ready`. It drives neither output.
- R8: A synchronous active-high `rst` clears any pending escape, so the first byte after reset is treated as unescaped.
- R9: The input 01 02 A5 03 04 A5 A5 05 06 A5 A5 A5 07 08 A5 A5 A5 A5 09 0A produces 01 02 04 A5 05 06 A5 08 A5 A5 09 0A on data and 03 07 on control.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_valid | input | 1 | Input byte is offered |
| src_ready | output | 1 | Input byte is accepted this cycle |
| src_byte | input | DATA_W | Input byte |
| dat_valid | output | 1 | Data output byte valid |
| dat_ready | input | 1 | Data output sink can take a byte |
| dat_byte | output | DATA_W | Data output byte |
| ctl_valid | output | 1 | Control output byte valid |
| ctl_ready | input | 1 | Control output sink can take a byte |
| ctl_byte | output | DATA_W | Control output byte |

## Verification
The assertions assume that `rst` is held for at least one clock edge before traffic starts. They also assume that `src_byte` is a known value whenever `src_valid` is high, because the route and the pending-bit checks are decoded from that byte.

The stimulus changes its inputs only on falling edges and keeps `src_byte` driven at all times. It lowers the ready inputs only in the directed back-pressure cases, so every stall the properties look at is a deliberate one.

// File: rtl/esc_pkg.sv
package esc_pkg;

    typedef enum logic [1:0] {
        DST_NONE = 2'd0,
        DST_DAT  = 2'd1,
        DST_CTL  = 2'd2
    } dest_e;

    typedef struct packed {
        dest_e dest;    // where the current byte goes
        logic  arm;     // byte opens an escape
        logic  disarm;  // byte closes an escape
    } route_t;

    function automatic route_t decide(input logic is_esc, input logic pending);
        route_t r;
        r.dest   = DST_NONE;
        r.arm    = 1'b0;
        r.disarm = 1'b0;
        if (!pending) begin
            if (is_esc) r.arm  = 1'b1;
            else        r.dest = DST_DAT;
        end else begin
            r.disarm = 1'b1;
            r.dest   = is_esc ? DST_DAT : DST_CTL;
        end
        return r;
    endfunction

endpackage

// File: rtl/esc_route_decode.sv
module esc_route_decode
    import esc_pkg::*;
#(
    parameter int          DATA_W   = 8,
    parameter logic [7:0]  ESC_CODE = 8'hA5
) (
    input  logic [DATA_W-1:0] byte_in,
    input  logic              pending,
    output route_t            route
);
    localparam logic [DATA_W-1:0] ESC_W = DATA_W'(ESC_CODE);

    logic is_esc;

    always_comb begin
        is_esc = (byte_in == ESC_W);
        route  = decide(is_esc, pending);
    end

endmodule

// File: rtl/esc_pending_reg.sv
module esc_pending_reg
    import esc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   fire,
    input  route_t route,
    output logic   pending
);

    always_ff @(posedge clk) begin
        if (rst)                      pending <= 1'b0;
        else if (fire && route.arm)   pending <= 1'b1;
        else if (fire && route.disarm) pending <= 1'b0;
    end

    AST_PEND_SET: assert property (@(posedge clk) disable iff (rst)
        (fire && !pending && route.arm) |=> pending);                // R5
    AST_PEND_CLR: assert property (@(posedge clk) disable iff (rst)
        (fire && pending) |=> !pending);                             // R5
    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(pending));                                 // R6

endmodule

// File: rtl/esc_out_mux.sv
module esc_out_mux
    import esc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_byte,
    input  route_t            route,
    input  logic              dat_ready,
    input  logic              ctl_ready,
    output logic              src_ready,
    output logic              fire,
    output logic              dat_valid,
    output logic [DATA_W-1:0] dat_byte,
    output logic              ctl_valid,
    output logic [DATA_W-1:0] ctl_byte
);

    always_comb begin
        unique case (route.dest)
            DST_DAT: src_ready = dat_ready;
            DST_CTL: src_ready = ctl_ready;
            default: src_ready = 1'b1;
        endcase
        dat_valid = src_valid && (route.dest == DST_DAT);
        ctl_valid = src_valid && (route.dest == DST_CTL);
        dat_byte  = src_byte;
        ctl_byte  = src_byte;
        fire      = src_valid && src_ready;
    end

    AST_DAT_WAIT: assert property (@(posedge clk) disable iff (rst)
        (dat_valid && !dat_ready) |-> !src_ready);                   // R6
    AST_CTL_WAIT: assert property (@(posedge clk) disable iff (rst)
        (ctl_valid && !ctl_ready) |-> !src_ready);                   // R6

endmodule

// File: rtl/esc_unescaper.sv
module esc_unescaper
    import esc_pkg::*;
#(
    parameter int         DATA_W   = 8,
    parameter logic [7:0] ESC_CODE = 8'hA5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              src_valid,
    output logic              src_ready,
    input  logic [DATA_W-1:0] src_byte,
    output logic              dat_valid,
    input  logic              dat_ready,
    output logic [DATA_W-1:0] dat_byte,
    output logic              ctl_valid,
    input  logic              ctl_ready,
    output logic [DATA_W-1:0] ctl_byte
);
    localparam logic [DATA_W-1:0] ESC_W = DATA_W'(ESC_CODE);

    route_t route;
    logic   pending;
    logic   fire;

    esc_route_decode #(.DATA_W(DATA_W), .ESC_CODE(ESC_CODE)) u_dec (
        .byte_in (src_byte),
        .pending (pending),
        .route   (route)
    );

    esc_out_mux #(.DATA_W(DATA_W)) u_mux (
        .clk       (clk),
        .rst       (rst),
        .src_valid (src_valid),
        .src_byte  (src_byte),
        .route     (route),
        .dat_ready (dat_ready),
        .ctl_ready (ctl_ready),
        .src_ready (src_ready),
        .fire      (fire),
        .dat_valid (dat_valid),
        .dat_byte  (dat_byte),
        .ctl_valid (ctl_valid),
        .ctl_byte  (ctl_byte)
    );

    esc_pending_reg u_pend (
        .clk     (clk),
        .rst     (rst),
        .fire    (fire),
        .route   (route),
        .pending (pending)
    );

    AST_ONE_OUT: assert property (@(posedge clk) disable iff (rst)
        !(dat_valid && ctl_valid));                                  // R4
    AST_CTL_NOT_ESC: assert property (@(posedge clk) disable iff (rst)
        ctl_valid |-> (ctl_byte != ESC_W));                          // R3
    AST_LONE_ESC: assert property (@(posedge clk) disable iff (rst)
        (src_valid && !pending && src_byte == ESC_W)
            |-> (src_ready && !dat_valid && !ctl_valid));            // R7
    AST_ESC_AFTER_PEND: assert property (@(posedge clk) disable iff (rst)
        (src_valid && pending && src_byte == ESC_W) |-> dat_valid);  // R2

endmodule

// File: tb/esc_unescaper_test.sv
module esc_unescaper_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       src_valid, src_ready;
    logic [7:0] src_byte;
    logic       dat_valid, dat_ready;
    logic [7:0] dat_byte;
    logic       ctl_valid, ctl_ready;
    logic [7:0] ctl_byte;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    esc_unescaper uut (
        .clk(clk), .rst(rst),
        .src_valid(src_valid), .src_ready(src_ready), .src_byte(src_byte),
        .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_byte(dat_byte),
        .ctl_valid(ctl_valid), .ctl_ready(ctl_ready), .ctl_byte(ctl_byte)
    );

    localparam int NS = 20;
    localparam int NA = 12;
    localparam int NB = 2;
    localparam logic [7:0] STIM [NS] = '{8'h01, 8'h02, 8'hA5, 8'h03, 8'h04, 8'hA5, 8'hA5,
        8'h05, 8'h06, 8'hA5, 8'hA5, 8'hA5, 8'h07, 8'h08, 8'hA5, 8'hA5, 8'hA5, 8'hA5, 8'h09, 8'h0A};
    localparam logic [7:0] EXP_DAT [NA] = '{8'h01, 8'h02, 8'h04, 8'hA5, 8'h05, 8'h06,
        8'hA5, 8'h08, 8'hA5, 8'hA5, 8'h09, 8'h0A};
    localparam logic [7:0] EXP_CTL [NB] = '{8'h03, 8'h07};

    logic [7:0] got_dat [32];
    logic [7:0] got_ctl [32];
    int na, nb;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // offer one byte at a falling edge, inspect outputs, let the rising edge pass
    task automatic offer(input logic [7:0] b);
        @(negedge clk);
        src_valid = 1'b1;
        src_byte  = b;
        #1;
        if (dat_valid && dat_ready && src_ready) begin got_dat[na] = dat_byte; na++; end
        if (ctl_valid && ctl_ready && src_ready) begin got_ctl[nb] = ctl_byte; nb++; end
    endtask

    task automatic idle();
        @(negedge clk);
        src_valid = 1'b0;
        src_byte  = 8'h00;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; src_valid = 1'b0; src_byte = 8'h00;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; src_valid = 1'b0; src_byte = 8'h00;
        dat_ready = 1'b1; ctl_ready = 1'b1;
        na = 0; nb = 0;
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R8 reset state: nothing offered, nothing out
        chk("R8 idle dat_valid", 32'(dat_valid), 0);
        chk("R8 idle ctl_valid", 32'(ctl_valid), 0);

        // R9 / R1 / R2 / R3 / R5: reference sequence, both sinks ready
        for (int i = 0; i < NS; i++) offer(STIM[i]);
        idle();
        chk("R9 data count", 32'(na), NA);
        chk("R9 control count", 32'(nb), NB);
        for (int i = 0; i < NA; i++) chk("R9 R1 R2 data byte", 32'(got_dat[i]), 32'(EXP_DAT[i]));
        for (int i = 0; i < NB; i++) chk("R9 R3 control byte", 32'(got_ctl[i]), 32'(EXP_CTL[i]));

        // R5: A5 A5 A5 07 -> A5 on data, 07 on control
        na = 0; nb = 0;
        offer(8'hA5); offer(8'hA5); offer(8'hA5); offer(8'h07); idle();
        chk("R5 triple data count", 32'(na), 1);
        chk("R5 triple data byte", 32'(got_dat[0]), 32'hA5);
        chk("R5 triple control byte", 32'(got_ctl[0]), 32'h07);

        // R7: lone escape accepted while both sinks stalled, no output
        dat_ready = 1'b0; ctl_ready = 1'b0;
        @(negedge clk); src_valid = 1'b1; src_byte = 8'hA5; #1;
        chk("R7 lone esc ready", 32'(src_ready), 1);
        chk("R7 lone esc no output", 32'({dat_valid, ctl_valid}), 0);
        // R6: next byte goes to control, stalled; pending must hold
        @(negedge clk); src_byte = 8'h33; #1;
        chk("R6 ctl stall ready", 32'(src_ready), 0);
        chk("R3 ctl valid", 32'(ctl_valid), 1);
        @(negedge clk); #1;
        chk("R6 held after stall", 32'({ctl_valid, dat_valid}), 32'b10);
        chk("R4 one output", 32'(dat_valid & ctl_valid), 0);
        @(negedge clk); ctl_ready = 1'b1; #1;
        chk("R6 released ready", 32'(src_ready), 1);
        chk("R3 ctl byte", 32'(ctl_byte), 32'h33);
        // R1 with data stall
        @(negedge clk); src_byte = 8'h10; #1;
        chk("R1 data valid", 32'({dat_valid, dat_byte}), 32'h110);
        chk("R6 data stall ready", 32'(src_ready), 0);
        @(negedge clk); dat_ready = 1'b1; #1;
        chk("R6 data release", 32'(src_ready), 1);
        // R2 with data stall on second escape
        @(negedge clk); src_byte = 8'hA5; #1;   // opens escape
        @(negedge clk); dat_ready = 1'b0; #1;   // second escape offered
        chk("R2 literal valid", 32'({dat_valid, dat_byte}), 32'h1A5);
        chk("R6 literal stall", 32'(src_ready), 0);
        @(negedge clk); dat_ready = 1'b1; #1;
        chk("R2 literal accepted", 32'(src_ready), 1);
        @(negedge clk); src_byte = 8'h44; #1;
        chk("R2 escape closed", 32'({dat_valid, dat_byte}), 32'h144);

        // R8: reset clears a pending escape
        @(negedge clk); src_byte = 8'hA5;
        do_reset();
        src_valid = 1'b1; src_byte = 8'h44; #1;
        chk("R8 pending cleared", 32'({dat_valid, ctl_valid}), 32'b10);
        idle();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule